// File: doc/BRIEF.md
# Cache Eviction Write-Back Burst Generator

When a cache line is evicted, this block turns the line state into the address-channel fields of the single write burst that carries the dirty data back to memory. Its inputs are three things: whether the line is valid, a dirty flag for each half of the 32-byte line, and the doubleword index of the access that caused the eviction. Every beat is 64 bits wide. A line with one dirty half produces a two-beat burst that covers only that half. A line with both halves dirty produces one four-beat burst that covers the whole line.

The burst order puts the triggering doubleword first whenever it lies in the data being written. A burst that cannot begin at its natural aligned start because of this becomes a wrapping burst. A request is accepted on a valid/ready handshake. The resulting burst fields are registered and held on the outputs until the downstream address channel accepts them. A new eviction is accepted only when no burst is pending.

Top module: `wb_evict_burst_gen`

## Requirements
- R1: Every issued burst has a transfer size code of 3'b011, meaning 64-bit beats.
- R2: The length field gives the beat count minus one. It is 1 for a half-line burst and 3 for a full-line burst.
- R3: When only the lower half is dirty, a trigger index of 1 (byte offset 0x08-0x0F) gives start offset 0x08 with a WRAP burst (2'b10). Any other trigger index gives start offset 0x00 with an INCR burst (2'b01).
- R4: When only the upper half is dirty, a trigger index of 3 (byte offset 0x18-0x1F) gives start offset 0x18 with WRAP. Any other trigger index gives start offset 0x10 with INCR.
- R5: When both halves are dirty and the line is valid, a trigger index of 0 gives start offset 0x00 with INCR. A trigger index of 1, 2 or 3 gives WRAP, and the burst starts at that doubleword (0x08, 0x10 or 0x18).
- R6: An accepted request whose line is invalid, or whose halves are both clean, issues no burst: aw_valid stays low and evict_ready stays high.
- R7: While aw_valid is high and aw_ready is low, aw_valid and every burst field stay unchanged, even if new requests are presented.
- R8: aw_valid rises on the cycle after a request that issues a burst is accepted, and falls on the cycle after the aw_valid/aw_ready handshake. evict_ready is low exactly while a burst is pending.
- R9: After reset, aw_valid is low and evict_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evict_valid | input | 1 | Eviction request present |
| evict_ready | output | 1 | Request can be accepted (no burst pending) |
| line_valid | input | 1 | Evicted line holds valid data |
| dirty_lo | input | 1 | Lower half of the line is dirty |
| dirty_hi | input | 1 | Upper half of the line is dirty |
| trig_idx | input | IDX_W (2) | Doubleword index of the triggering access (offset bits 4:3) |
| aw_valid | output | 1 | Burst address fields valid |
| aw_ready | input | 1 | Downstream accepts the burst |
| aw_off | output | IDX_W+3 (5) | Start byte offset within the line |
| aw_burst | output | 2 | 2'b01 INCR, 2'b10 WRAP |
| aw_size | output | 3 | Beat size code, 3'b011 for 64 bits |
| aw_len | output | LEN_W (8) | Beat count minus one |

## Verification
An accepted request passes through one register stage, so its burst fields and aw_valid appear one cycle after the accepting edge. The bench therefore drives the request at a falling edge and checks the outputs at the next falling edge. After a handshake, aw_valid must drop in the cycle that follows, which is checked one falling edge after aw_ready is raised. During stalls of random length, stray requests are presented and the fields are compared against the expected burst on every intervening falling edge.

// File: rtl/wb_burst_pkg.sv
package wb_burst_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10
  } burst_t;

  localparam int BEAT_BYTES_LOG2 = 3;
  localparam logic [2:0] SIZE_64 = 3'(BEAT_BYTES_LOG2);
endpackage

// File: rtl/wb_burst_decode.sv
module wb_burst_decode
  import wb_burst_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int LEN_W = 8
) (
  input  logic             line_valid,
  input  logic             dirty_lo,
  input  logic             dirty_hi,
  input  logic [IDX_W-1:0] trig_idx,
  output logic             issue,
  output logic [IDX_W-1:0] start_idx,
  output burst_t           burst,
  output logic [LEN_W-1:0] len
);
  localparam int LINE_DW = 1 << IDX_W;
  localparam int HALF_DW = LINE_DW / 2;
  localparam logic [LEN_W-1:0] LEN_HALF = LEN_W'(HALF_DW - 1);
  localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(LINE_DW - 1);

  logic             trig_half;
  logic [IDX_W-2:0] trig_sub;
  logic             sel_half;

  assign trig_half = trig_idx[IDX_W-1];
  assign trig_sub  = trig_idx[IDX_W-2:0];
  assign sel_half  = dirty_hi & ~dirty_lo;

  always_comb begin
    issue     = line_valid & (dirty_lo | dirty_hi);
    start_idx = '0;
    burst     = BURST_INCR;
    len       = LEN_HALF;
    if (dirty_lo && dirty_hi) begin
      len = LEN_FULL;
      if (trig_idx != '0) begin
        start_idx = trig_idx;
        burst     = BURST_WRAP;
      end
    end else begin
      if ((trig_half == sel_half) && (trig_sub != '0)) begin
        start_idx = trig_idx;
        burst     = BURST_WRAP;
      end else begin
        start_idx = {sel_half, {(IDX_W-1){1'b0}}};
      end
    end
  end
endmodule

// File: rtl/wb_burst_issue.sv
module wb_burst_issue
  import wb_burst_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             issue,
  input  logic [IDX_W-1:0] start_idx,
  input  burst_t           burst,
  input  logic [LEN_W-1:0] len,
  input  logic             aw_ready,
  output logic             pending,
  output logic [IDX_W-1:0] q_idx,
  output burst_t           q_burst,
  output logic [LEN_W-1:0] q_len
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      q_idx   <= '0;
      q_burst <= BURST_FIXED;
      q_len   <= '0;
    end else if (pending) begin
      if (aw_ready) pending <= 1'b0;
    end else if (accept) begin
      pending <= issue;
      if (issue) begin
        q_idx   <= start_idx;
        q_burst <= burst;
        q_len   <= len;
      end
    end
  end
endmodule

// File: rtl/wb_evict_burst_gen.sv
module wb_evict_burst_gen
  import wb_burst_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int LEN_W = 8,
  localparam int OFF_W = IDX_W + BEAT_BYTES_LOG2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evict_valid,
  output logic             evict_ready,
  input  logic             line_valid,
  input  logic             dirty_lo,
  input  logic             dirty_hi,
  input  logic [IDX_W-1:0] trig_idx,
  output logic             aw_valid,
  input  logic             aw_ready,
  output logic [OFF_W-1:0] aw_off,
  output logic [1:0]       aw_burst,
  output logic [2:0]       aw_size,
  output logic [LEN_W-1:0] aw_len
);
  logic             dec_issue;
  logic [IDX_W-1:0] dec_idx;
  burst_t           dec_burst;
  logic [LEN_W-1:0] dec_len;
  logic             pending;
  logic [IDX_W-1:0] q_idx;
  burst_t           q_burst;

  wb_burst_decode #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_dec (
    .line_valid (line_valid),
    .dirty_lo   (dirty_lo),
    .dirty_hi   (dirty_hi),
    .trig_idx   (trig_idx),
    .issue      (dec_issue),
    .start_idx  (dec_idx),
    .burst      (dec_burst),
    .len        (dec_len)
  );

  wb_burst_issue #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_iss (
    .clk       (clk),
    .rst       (rst),
    .accept    (evict_valid & evict_ready),
    .issue     (dec_issue),
    .start_idx (dec_idx),
    .burst     (dec_burst),
    .len       (dec_len),
    .aw_ready  (aw_ready),
    .pending   (pending),
    .q_idx     (q_idx),
    .q_burst   (q_burst),
    .q_len     (aw_len)
  );

  assign evict_ready = ~pending;
  assign aw_valid    = pending;
  assign aw_off      = {q_idx, {BEAT_BYTES_LOG2{1'b0}}};
  assign aw_burst    = q_burst;
  assign aw_size     = SIZE_64;
endmodule

// File: rtl/wb_evict_burst_chk.sv
module wb_evict_burst_chk #(
  parameter int OFF_W = 5,
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             evict_valid,
  input logic             evict_ready,
  input logic             line_valid,
  input logic             dirty_lo,
  input logic             dirty_hi,
  input logic             aw_valid,
  input logic             aw_ready,
  input logic [OFF_W-1:0] aw_off,
  input logic [1:0]       aw_burst,
  input logic [2:0]       aw_size,
  input logic [LEN_W-1:0] aw_len
);
  assert_size64_R1: assert property (@(posedge clk) disable iff (rst)
    aw_valid |-> aw_size == 3'b011);

  assert_len_code_R2: assert property (@(posedge clk) disable iff (rst)
    aw_valid |-> (aw_len == LEN_W'(1) || aw_len == LEN_W'(3)));

  assert_full_incr_start_R5: assert property (@(posedge clk) disable iff (rst)
    (aw_valid && aw_len == LEN_W'(3) && aw_burst == 2'b01) |-> aw_off == '0);

  assert_no_burst_R6: assert property (@(posedge clk) disable iff (rst)
    (evict_valid && evict_ready && !(line_valid && (dirty_lo || dirty_hi))) |=> !aw_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (aw_valid && !aw_ready) |=> (aw_valid && $stable(aw_off) && $stable(aw_burst) && $stable(aw_len)));

  assert_launch_R8: assert property (@(posedge clk) disable iff (rst)
    (evict_valid && evict_ready && line_valid && (dirty_lo || dirty_hi)) |=> aw_valid);

  assert_retire_R8: assert property (@(posedge clk) disable iff (rst)
    (aw_valid && aw_ready) |=> !aw_valid);

  assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
    aw_valid |-> !evict_ready);
endmodule

bind wb_evict_burst_gen wb_evict_burst_chk #(.OFF_W(OFF_W), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .evict_valid (evict_valid),
  .evict_ready (evict_ready),
  .line_valid  (line_valid),
  .dirty_lo    (dirty_lo),
  .dirty_hi    (dirty_hi),
  .aw_valid    (aw_valid),
  .aw_ready    (aw_ready),
  .aw_off      (aw_off),
  .aw_burst    (aw_burst),
  .aw_size     (aw_size),
  .aw_len      (aw_len)
);

// File: tb/wb_evict_burst_gen_tb.sv
module wb_evict_burst_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       evict_valid = 1'b0;
  logic       evict_ready;
  logic       line_valid = 1'b0;
  logic       dirty_lo = 1'b0;
  logic       dirty_hi = 1'b0;
  logic [1:0] trig_idx = '0;
  logic       aw_valid;
  logic       aw_ready = 1'b0;
  logic [4:0] aw_off;
  logic [1:0] aw_burst;
  logic [2:0] aw_size;
  logic [7:0] aw_len;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wb_evict_burst_gen u_dut (
    .clk(clk), .rst(rst), .evict_valid(evict_valid), .evict_ready(evict_ready),
    .line_valid(line_valid), .dirty_lo(dirty_lo), .dirty_hi(dirty_hi),
    .trig_idx(trig_idx), .aw_valid(aw_valid), .aw_ready(aw_ready),
    .aw_off(aw_off), .aw_burst(aw_burst), .aw_size(aw_size), .aw_len(aw_len)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Expected burst from the requirements, in byte-offset terms.
  function automatic void expect_burst(input bit lv, input bit lo, input bit hi,
                                       input int off, output bit go, output int st,
                                       output int bt, output int ln, output string rq);
    go = lv && (lo || hi);
    st = 0; bt = 1; ln = 1; rq = "R6";
    if (lo && hi) begin
      rq = "R5"; ln = 3;
      if (off >= 8) begin st = off & 24; bt = 2; end
    end else if (lo) begin
      rq = "R3";
      if (off >= 8 && off <= 15) begin st = 8; bt = 2; end
    end else if (hi) begin
      rq = "R4"; st = 16;
      if (off >= 24) begin st = 24; bt = 2; end
    end
  endfunction

  task automatic run_vec(input bit lv, input bit lo, input bit hi, input int off, input int stall);
    bit go; int st, bt, ln; string rq;
    expect_burst(lv, lo, hi, off, go, st, bt, ln, rq);
    @(negedge clk);
    chk("R8 ready before request", int'(evict_ready), 1);
    evict_valid = 1'b1; line_valid = lv; dirty_lo = lo; dirty_hi = hi;
    trig_idx = 2'(off >> 3);
    @(negedge clk);
    evict_valid = 1'b0;
    if (go) begin
      chk("R8 aw_valid after accept", int'(aw_valid), 1);
      chk({rq, " start offset"}, int'(aw_off), st);
      chk({rq, " burst type"}, int'(aw_burst), bt);
      chk("R2 length", int'(aw_len), ln);
      chk("R1 size", int'(aw_size), 3);
      chk("R8 busy", int'(evict_ready), 0);
      for (int i = 0; i < stall; i++) begin
        evict_valid = 1'b1; line_valid = 1'b1;
        dirty_lo = ~lo; dirty_hi = 1'b1; trig_idx = 2'($urandom);
        @(negedge clk);
        chk("R7 held valid", int'(aw_valid), 1);
        chk("R7 held offset", int'(aw_off), st);
        chk("R7 held burst", int'(aw_burst), bt);
        chk("R7 held length", int'(aw_len), ln);
      end
      evict_valid = 1'b0;
      aw_ready = 1'b1;
      @(negedge clk);
      aw_ready = 1'b0;
      chk("R8 valid drops after handshake", int'(aw_valid), 0);
    end else begin
      chk("R6 no burst", int'(aw_valid), 0);
      chk("R6 still ready", int'(evict_ready), 1);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset aw_valid", int'(aw_valid), 0);
    chk("R9 reset evict_ready", int'(evict_ready), 1);

    // Directed: every doubleword with every dirty pattern, valid and invalid line.
    for (int v = 0; v < 2; v++)
      for (int d = 0; d < 4; d++)
        for (int w = 0; w < 4; w++)
          run_vec(v[0], d[0], d[1], w * 8 + 5, w % 3);

    // Random mix.
    for (int k = 0; k < 400; k++)
      run_vec(($urandom % 8) != 0, 1'($urandom), 1'($urandom), int'($urandom % 32),
              int'($urandom % 4));

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule